// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block is a master-mode serial audio sender. It generates its own bit clock and frame-select line from the system clock. It takes audio words from an eight-entry internal queue and shifts them out most significant bit first on one serial data line. A small configuration bus sets five things: one of five framing schemes (two-channel standard, left-aligned, right-aligned, short-pulse PCM and long-pulse PCM), the word width, the slot width and, for PCM, the number of slots per frame.

Software or a producer writes words into the queue one at a time, in the order left, right, left, right. A ready output tells the producer that room remains for a complete pair. Streaming is started and stopped with a level-sensitive enable. The configuration is captured when streaming starts.

At the start of streaming the block emits one lead-in bit period, whose data bit is zero, before the first frame. This lets the frame-select edge or pulse that marks a frame start appear in the bit period before the first data bit. If the queue has run dry when a slot begins, that slot goes out as zeros and a sticky underrun flag is raised. When enable is removed, the current frame completes before the outputs return to idle.

Top module: `serial_audio_tx`

## Requirements
- R1: Configuration is captured at the start of streaming.
  - Format codes: 0 standard two-channel, 1 left-aligned, 2 right-aligned, 3 short-pulse PCM, 4 long-pulse PCM.
  - Word codes: 0→8, 1→10, 2→16, 3→20, 4→24, 5→32 bits.
  - Slot codes: 0→same as word, 1→16, 2→32 bits. A slot is never narrower than the word.
  - `cfg_nslots` holds the slot count minus one, for PCM only.
  - A frame lasts slot×slots bit periods in PCM and 2×slot in the other formats.
- R2: Standard two-channel format (code 0):
  - The frame select is low for the left slot and high for the right slot.
  - It changes one bit period before each slot's first bit.
  - Bits after the word inside a slot are zero.
- R3: Left-aligned format (code 1) matches code 0, except that the frame select changes in the same bit period as the slot's first bit.
- R4: Right-aligned format (code 2):
  - The frame select timing is that of code 1.
  - The word ends at the slot's last bit, so the slot opens with slot−word zero bits.
- R5: Short-pulse PCM (code 3):
  - The frame select is high for exactly the one bit period before each frame's first bit.
  - Words are left-aligned in their slots.
- R6: Long-pulse PCM (code 4):
  - The frame select is high for the first 13 bit periods of each frame.
  - Words are left-aligned in their slots.
- R7: Bit clock and data edges:
  - A bit period is 2×HALF_DIV clocks.
  - The data line and frame select change only on the launch edge of the bit clock: falling for codes 0–2, rising for codes 3–4.
  - The receiver samples on the opposite edge.
- R8: Queue writes and ready:
  - Each cycle with `wr_valid` high stores one word if the queue is not full.
  - Words are sent in write order, the first word of a pair in the first (left) slot.
  - `wr_ready` is high exactly when at least two entries are free.
- R9: Starting from idle empties the queue, discarding words written while idle, and clears the underrun flag. `busy` rises one clock after `enable` is seen high.
- R10: A slot that begins while the queue is empty is sent as all zeros, and sets `underrun`. The flag stays set until the next start.
- R11: Stopping:
  - After `enable` falls, the frame in progress completes.
  - `busy` then falls, and bit clock, frame select and data are all low while idle.
  - While `enable` stays high, `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Stream request; rising from idle starts, falling stops at frame end |
| cfg_fmt | input | 3 | Framing scheme code |
| cfg_word | input | 3 | Word width code |
| cfg_slot | input | 2 | Slot width code |
| cfg_nslots | input | NSW (3) | PCM slot count minus one |
| wr_valid | input | 1 | Write one word into the queue |
| wr_data | input | DATA_W (32) | Word to write; the low word-width bits are sent |
| wr_ready | output | 1 | Room for at least one more pair |
| sck | output | 1 | Bit clock |
| fs | output | 1 | Frame select |
| sd | output | 1 | Serial data |
| busy | output | 1 | Streaming in progress |
| underrun | output | 1 | Sticky empty-queue flag |

## Verification
All outputs are registered.

- **Start.** `busy`, the flush of the queue and the clearing of `underrun` are visible one clock after `enable` is sampled high.
- **Writes.** A write changes `wr_ready` one clock later.
- **Serial stream.** The bit clock, data and frame select of a bit period all change on one clock edge. The capture edge follows HALF_DIV clocks later.

The bench drives inputs and samples on the falling system clock, so every registered change has settled before it is read. The monitor checks data and frame select only at the capture transitions it sees on `sck`. It also checks that consecutive captures are exactly 2×HALF_DIV clocks apart. It derives each expected bit from the frame position it tracks from the lead-in bit and from a queue of the words written.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam logic [2:0] FMT_STD   = 3'd0;
    localparam logic [2:0] FMT_LEFT  = 3'd1;
    localparam logic [2:0] FMT_RIGHT = 3'd2;
    localparam logic [2:0] FMT_PCM_S = 3'd3;
    localparam logic [2:0] FMT_PCM_L = 3'd4;

    // Word width in bits from its code
    function automatic logic [5:0] word_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd8;
            3'd1:    return 6'd10;
            3'd2:    return 6'd16;
            3'd3:    return 6'd20;
            3'd4:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    // Slot width from its code; never narrower than the word
    function automatic logic [5:0] slot_bits(input logic [1:0] code, input logic [5:0] ws);
        logic [5:0] s;
        case (code)
            2'd1:    s = 6'd16;
            2'd2:    s = 6'd32;
            default: s = ws;
        endcase
        return (s < ws) ? ws : s;
    endfunction

    function automatic logic is_pcm(input logic [2:0] fmt);
        return (fmt == FMT_PCM_S) || (fmt == FMT_PCM_L);
    endfunction

endpackage

// File: rtl/sat_fifo.sv
module sat_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH):0]       count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && !flush && (q.cnt != CW'(DEPTH));
        do_pop  = pop  && !flush && (q.cnt != '0);
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = q.wp + 1'b1;
            if (do_pop)  d.rp = q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= din;
    end

    assign dout  = mem[q.rp];
    assign count = q.cnt;

endmodule

// File: rtl/sat_slot_fmt.sv
module sat_slot_fmt
    import sat_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int KW          = 9,
    parameter int LONG_FS_LEN = 13
) (
    input  logic [2:0]        fmt,
    input  logic [5:0]        ws,
    input  logic [5:0]        ss,
    input  logic [KW-1:0]     frl,
    input  logic [KW-1:0]     k,
    input  logic [5:0]        b,
    input  logic [DATA_W-1:0] word,
    output logic              sd_bit,
    output logic              fs_lvl
);
    localparam int IW = $clog2(DATA_W);

    logic [KW-1:0] ssk, kp1;
    logic [5:0]    off;

    always_comb begin
        off    = ss - ws;
        sd_bit = 1'b0;
        if (fmt == FMT_RIGHT) begin
            if (b >= off) sd_bit = word[IW'(ss - 6'd1 - b)];
        end else begin
            if (b < ws)   sd_bit = word[IW'(ws - 6'd1 - b)];
        end
    end

    always_comb begin
        ssk = KW'(ss);
        kp1 = k + 1'b1;
        case (fmt)
            FMT_LEFT, FMT_RIGHT: fs_lvl = (k >= ssk);
            FMT_PCM_S:           fs_lvl = (kp1 == frl);
            FMT_PCM_L:           fs_lvl = (k < KW'(LONG_FS_LEN));
            default:             fs_lvl = (kp1 >= ssk) && (kp1 < (ssk << 1));
        endcase
    end

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
    import sat_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int FIFO_DEPTH  = 8,
    parameter int MAX_SLOTS   = 8,
    parameter int HALF_DIV    = 4,
    parameter int LONG_FS_LEN = 13,
    localparam int NSW        = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [2:0]        cfg_fmt,
    input  logic [2:0]        cfg_word,
    input  logic [1:0]        cfg_slot,
    input  logic [NSW-1:0]    cfg_nslots,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              sck,
    output logic              fs,
    output logic              sd,
    output logic              busy,
    output logic              underrun
);
    localparam int KW = $clog2(DATA_W * MAX_SLOTS) + 1;
    localparam int PW = $clog2(2 * HALF_DIV);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;
    localparam logic [PW-1:0] PH_LAST = PW'(2 * HALF_DIV - 1);

    typedef struct packed {
        logic              running;
        logic              sck;
        logic              fs;
        logic              sd;
        logic              underrun;
        logic [2:0]        fmt;
        logic [5:0]        ws;
        logic [5:0]        ss;
        logic [KW-1:0]     frl;
        logic [PW-1:0]     ph;
        logic [KW-1:0]     k;
        logic [5:0]        b;
        logic [DATA_W-1:0] word;
    } tx_st_t;

    tx_st_t q, d;

    logic              start;
    logic [5:0]        st_ws, st_ss;
    logic [KW-1:0]     st_frl;
    logic [KW-1:0]     adv_k;
    logic [5:0]        adv_b;
    logic [DATA_W-1:0] fifo_dout, new_word;
    logic [CW-1:0]     fifo_cnt;
    logic              fifo_pop, flush;
    logic [2:0]        f_fmt;
    logic [5:0]        f_ws, f_ss, f_b;
    logic [KW-1:0]     f_frl, f_k;
    logic [DATA_W-1:0] f_word;
    logic              f_sd, f_fs;
    logic [PW-1:0]     ph_n;

    // Start-of-stream decode of the configuration bus
    assign start  = enable && !q.running;
    assign st_ws  = word_bits(cfg_word);
    assign st_ss  = slot_bits(cfg_slot, st_ws);
    assign st_frl = is_pcm(cfg_fmt) ? (KW'(st_ss) * (KW'(cfg_nslots) + 1'b1))
                                    : (KW'(st_ss) << 1);

    // Position of the next bit period
    assign adv_k    = (q.k == q.frl - 1'b1) ? '0 : q.k + 1'b1;
    assign adv_b    = (q.b == q.ss - 6'd1) ? '0 : q.b + 6'd1;
    assign new_word = (fifo_cnt != '0) ? fifo_dout : '0;

    // Formatter operands: lead-in bit at start, next bit otherwise
    assign f_fmt  = start ? cfg_fmt : q.fmt;
    assign f_ws   = start ? st_ws   : q.ws;
    assign f_ss   = start ? st_ss   : q.ss;
    assign f_frl  = start ? st_frl  : q.frl;
    assign f_k    = start ? st_frl - 1'b1 : adv_k;
    assign f_b    = start ? st_ss - 6'd1  : adv_b;
    assign f_word = start ? '0 : ((adv_b == '0) ? new_word : q.word);

    sat_slot_fmt #(
        .DATA_W      (DATA_W),
        .KW          (KW),
        .LONG_FS_LEN (LONG_FS_LEN)
    ) u_fmt (
        .fmt    (f_fmt),
        .ws     (f_ws),
        .ss     (f_ss),
        .frl    (f_frl),
        .k      (f_k),
        .b      (f_b),
        .word   (f_word),
        .sd_bit (f_sd),
        .fs_lvl (f_fs)
    );

    sat_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (wr_valid),
        .din   (wr_data),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .count (fifo_cnt)
    );

    always_comb begin
        d        = q;
        fifo_pop = 1'b0;
        flush    = 1'b0;
        ph_n     = q.ph + 1'b1;
        if (start) begin
            flush      = 1'b1;
            d.running  = 1'b1;
            d.underrun = 1'b0;
            d.fmt      = cfg_fmt;
            d.ws       = st_ws;
            d.ss       = st_ss;
            d.frl      = st_frl;
            d.ph       = '0;
            d.k        = f_k;
            d.b        = f_b;
            d.word     = '0;
            d.sd       = f_sd;
            d.fs       = f_fs;
            d.sck      = is_pcm(cfg_fmt);
        end else if (q.running) begin
            if (q.ph != PH_LAST) begin
                d.ph  = ph_n;
                d.sck = (ph_n < PW'(HALF_DIV)) ? is_pcm(q.fmt) : !is_pcm(q.fmt);
            end else if ((q.k == q.frl - 1'b1) && !enable) begin
                d.running = 1'b0;
                d.ph      = '0;
                d.sck     = 1'b0;
                d.fs      = 1'b0;
                d.sd      = 1'b0;
            end else begin
                d.ph  = '0;
                d.k   = adv_k;
                d.b   = adv_b;
                d.sck = is_pcm(q.fmt);
                if (adv_b == '0) begin
                    fifo_pop = (fifo_cnt != '0);
                    d.word   = new_word;
                    if (fifo_cnt == '0) d.underrun = 1'b1;
                end
                d.sd = f_sd;
                d.fs = f_fs;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_ready = (CW'(FIFO_DEPTH) - fifo_cnt) >= CW'(2);
    assign sck      = q.sck;
    assign fs       = q.fs;
    assign sd       = q.sd;
    assign busy     = q.running;
    assign underrun = q.underrun;

endmodule

// File: rtl/sat_checker.sv
module sat_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic sck,
    input logic fs,
    input logic sd,
    input logic busy,
    input logic underrun
);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && !fs && !sd));

    assert_hold_while_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && busy) |=> busy);

    assert_data_on_clock_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (sd != $past(sd))) |-> (sck != $past(sck)));

    assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(underrun)) |-> underrun);

    assert_start_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !underrun);
endmodule

bind serial_audio_tx sat_checker u_sat_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .sck      (sck),
    .fs       (fs),
    .sd       (sd),
    .busy     (busy),
    .underrun (underrun)
);

// File: tb/tb_serial_audio_tx.sv
module tb_serial_audio_tx;
    localparam int HALF     = 4;
    localparam int BIT_CLKS = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  cfg_fmt = '0;
    logic [2:0]  cfg_word = '0;
    logic [1:0]  cfg_slot = '0;
    logic [2:0]  cfg_nslots = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready, sck, fs, sd, busy, underrun;

    always #2.5 clk = ~clk;

    serial_audio_tx #(.DATA_W(32), .FIFO_DEPTH(8), .MAX_SLOTS(8), .HALF_DIV(HALF), .LONG_FS_LEN(13)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_fmt(cfg_fmt), .cfg_word(cfg_word),
        .cfg_slot(cfg_slot), .cfg_nslots(cfg_nslots), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .sck(sck), .fs(fs), .sd(sd), .busy(busy), .underrun(underrun)
    );

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // model of the expected stream
    int m_fmt, m_ws, m_ss, m_frl;
    bit m_pcm;
    logic [31:0] exp_q[$];
    bit exp_under;
    int cap_cnt;
    int m_k;
    logic [31:0] m_word;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string fmt_tag(input int f);
        case (f)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic bit exp_sd_f(input int b, input logic [31:0] w);
        if (m_fmt == 2) begin
            if (b < m_ss - m_ws) return 1'b0;
            return w[m_ss - 1 - b];
        end
        if (b < m_ws) return w[m_ws - 1 - b];
        return 1'b0;
    endfunction

    function automatic bit exp_fs_f(input int k);
        case (m_fmt)
            0: return (k >= m_ss - 1) && (k < 2 * m_ss - 1);
            1, 2: return k >= m_ss;
            3: return k == m_frl - 1;
            default: return k < 13;
        endcase
    endfunction

    // monitor: scoreboard pop and compare at each capture edge
    initial begin
        bit p_sck, p_busy, p_sd, first;
        int cyc, last_cap;
        p_sck = 0; p_busy = 0; p_sd = 0; first = 0; cyc = 0; last_cap = 0;
        cap_cnt = 0; m_k = 0; m_word = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (busy && !p_busy) begin
                cap_cnt = 0; first = 1; m_k = m_frl - 1; m_word = '0;
            end
            if (busy && p_busy && (sd != p_sd))
                check((sck != p_sck) && (sck == m_pcm), "R7", "data change off launch edge", sck, m_pcm);
            if (busy && (sck != p_sck) && (sck == !m_pcm)) begin
                if (!first) begin
                    check(cyc - last_cap == BIT_CLKS, "R7", "bit period clocks", cyc - last_cap, BIT_CLKS);
                    m_k = (m_k + 1) % m_frl;
                    if (m_k % m_ss == 0) begin
                        if (exp_q.size() > 0) m_word = exp_q.pop_front();
                        else begin m_word = '0; exp_under = 1; end
                    end
                end
                first = 0;
                last_cap = cyc;
                cap_cnt++;
                check(sd == exp_sd_f(m_k % m_ss, m_word), fmt_tag(m_fmt), "data bit", sd, exp_sd_f(m_k % m_ss, m_word));
                check(fs == exp_fs_f(m_k), fmt_tag(m_fmt), "frame select", fs, exp_fs_f(m_k));
            end
            if (!busy && p_busy) begin
                check(m_k == m_frl - 1, "R11", "stop position in frame", m_k, m_frl - 1);
                check((cap_cnt - 1) % m_frl == 0, "R1", "whole frames sent", (cap_cnt - 1) % m_frl, 0);
                check(!sck && !fs && !sd, "R11", "idle levels", {sck, fs, sd}, 0);
            end
            p_sck = sck; p_busy = busy; p_sd = sd;
        end
    end

    task automatic write_word(input logic [31:0] v);
        wr_valid = 1'b1; wr_data = v;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // driver: configure, start, feed words, stop
    task automatic run(input int tnum, input int f, input int wc, input int sc, input int nc,
                       input int nw, input int frames);
        logic [63:0] mask;
        cfg_fmt = 3'(f); cfg_word = 3'(wc); cfg_slot = 2'(sc); cfg_nslots = 3'(nc);
        case (wc) 0: m_ws = 8; 1: m_ws = 10; 2: m_ws = 16; 3: m_ws = 20; 4: m_ws = 24; default: m_ws = 32; endcase
        m_ss = (sc == 1) ? 16 : (sc == 2) ? 32 : m_ws;
        if (m_ss < m_ws) m_ss = m_ws;
        m_fmt = f;
        m_pcm = (f == 3) || (f == 4);
        m_frl = m_pcm ? m_ss * (nc + 1) : 2 * m_ss; // R1 frame length
        mask = (64'd1 << m_ws) - 1;
        exp_q.delete();
        exp_under = 0;
        enable = 1'b1;
        @(negedge clk);
        check(busy == 1, "R9", "busy one clock after start", busy, 1);
        check(wr_ready == 1, "R9", "queue flushed on start", wr_ready, 1);
        check(underrun == 0, "R9", "underrun cleared on start", underrun, 0);
        for (int i = 0; i < nw; i++) begin
            logic [31:0] v;
            v = 32'(32'h9E3779B9 * (i + 1 + 17 * tnum)) ^ 32'h5A5A_0F0F;
            while (!wr_ready) @(negedge clk);
            exp_q.push_back(v & mask[31:0]);
            write_word(v);
        end
        while (cap_cnt < 1 + (frames - 1) * m_frl + 2) @(negedge clk);
        enable = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(underrun == exp_under, "R10", "sticky underrun after zero slots", underrun, exp_under);
        check(exp_q.size() == 0, "R8", "all written words sent in order", exp_q.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !sck && !fs && !sd, "R11", "reset idle levels", {busy, sck, fs, sd}, 0);
        check(wr_ready == 1, "R8", "ready after reset", wr_ready, 1);
        check(underrun == 0, "R10", "underrun clear after reset", underrun, 0);
        // R8: fill while idle; ready needs two free entries
        for (int i = 0; i < 6; i++) write_word(32'hDEAD_0000 + 32'(i));
        check(wr_ready == 1, "R8", "ready with two free", wr_ready, 1);
        write_word(32'hDEAD_0006);
        check(wr_ready == 0, "R8", "not ready with one free", wr_ready, 0);
        write_word(32'hDEAD_0007);
        write_word(32'hDEAD_0008);
        check(wr_ready == 0, "R8", "not ready when full", wr_ready, 0);
        // stale idle words must be discarded (R9)
        run(1, 0, 2, 0, 0, 6, 4);  // standard, 16/16
        run(2, 1, 2, 2, 0, 4, 3);  // left-aligned, 16 in 32
        run(3, 2, 4, 2, 0, 4, 3);  // right-aligned, 24 in 32
        run(4, 3, 2, 1, 3, 10, 4); // short-pulse PCM, 4 slots of 16
        run(5, 4, 0, 1, 1, 4, 3);  // long-pulse PCM, 8 in 16, 2 slots
        run(6, 0, 5, 0, 0, 4, 3);  // standard, 32/32
        run(7, 1, 1, 1, 0, 4, 3);  // left-aligned, 10 in 16
        run(8, 3, 3, 2, 0, 3, 4);  // short-pulse PCM, 1 slot, 20 in 32
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL R11 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule